// File: doc/BRIEF.md
# Block Address Translation Matcher

This block turns a 32-bit effective address into a physical page address. It uses a small set of block-translation entries instead of a page table. There are two banks of entries. Instruction fetches look only at the instruction bank, and all other accesses look only at the data bank. Each entry is a pair of 32-bit words:

- The tag word holds a segment nibble, a block index, a variable block-length mask and two privilege-valid bits.
- The target word holds the physical block number and the permission bits.

The block-length mask sets the block size. Address bits under the mask are not compared, and they are carried through into the physical address.

Software-side logic loads the entries one word at a time through a simple write port. A lookup returns four results: a hit flag, a page-aligned physical address, and read and write permission. If the relocation enable for the access class is off, the address passes through untranslated with full permission. A miss is reported with all results cleared, so that a later stage can walk the page table. The response is registered: it appears one clock after the request is sampled.

Top module: `bat_xlate`

## Requirements
- R1: After synchronous reset every response output is zero. Every stored word is zero, so a translated lookup misses.
- R2: A lookup with `req_fetch`=1 uses only instruction-bank entries (`cfg_bank`=1). A lookup with `req_fetch`=0 uses only data-bank entries (`cfg_bank`=0).
- R3: An entry can match only if `req_va[31:28]` equals tag-word bits 31:28 exactly.
- R4: Tag-word bits 12:2 form an 11-bit mask `m` over address bits 27:17. An entry matches only if (`req_va[27:17]` AND NOT `m`) equals tag-word bits 27:17.
- R5: A matching entry is valid for supervisor lookups (`req_user`=0) only if tag-word bit 1 is set. It is valid for user lookups (`req_user`=1) only if tag-word bit 0 is set.
- R6: On a translated hit, `rsp_pa` is formed as follows:
  - bits 31:28 are target-word bits 31:28;
  - bits 27:17 are (`req_va[27:17]` AND `m`) OR target-word bits 27:17;
  - bits 16:12 are `req_va[16:12]`;
  - bits 11:0 are zero.
- R7: Permission comes from the target word of the hit entry:
  - if target bit 1 is set, read and write are both granted;
  - else if target bit 0 is set, read only is granted;
  - else no permission is granted, although the lookup still hits.
- R8: When several valid entries match, the entry with the lowest index supplies the result. An entry that matches but is not valid for the current privilege is skipped.
- R9: If relocation is off for the access class, the lookup returns `rsp_hit`=1, read and write permission, and `rsp_pa` = {`req_va[31:12]`, 12'h000}. The relocation enable is `xlate_instr_en` for fetches and `xlate_data_en` otherwise.
- R10: Timing:
  - the response to a request sampled at a clock edge appears after that edge, and `rsp_valid` follows `req_valid` with one cycle of delay;
  - a word written at an edge is used only by lookups sampled at later edges.
- R11: A translated lookup that finds no valid matching entry returns `rsp_hit`=0, `rsp_pa`=0 and no permission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one entry word |
| cfg_bank | input | 1 | 1 = instruction bank, 0 = data bank |
| cfg_idx | input | IDX_W | Entry index within the bank |
| cfg_lower | input | 1 | 1 = target word, 0 = tag word |
| cfg_wdata | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_va | input | 32 | Effective address |
| xlate_instr_en | input | 1 | Relocation enable for fetches |
| xlate_data_en | input | 1 | Relocation enable for data accesses |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found, or bypass |
| rsp_pa | output | 32 | Physical page address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |

## Verification
Every lookup result is due exactly one clock after the edge that samples the request. The bench drives requests on the falling edge and pushes the expected result into a queue at the same moment. It computes that result from a shadow copy of the written words. A monitor pops and compares on the next falling edge, after the registered outputs have settled. A write and a lookup issued in the same cycle are scored against the shadow before the write, which checks that a new word is seen only from the following edge. An idle cycle is checked for a low `rsp_valid` one falling edge later.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int BLK_LSB  = 17;
  localparam int SEG_LSB  = 28;
  localparam int BLK_W    = SEG_LSB - BLK_LSB;
  localparam int OFS_W    = BLK_LSB - PAGE_LSB;
  localparam int SEG_W    = ADDR_W - SEG_LSB;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] pa;
    logic              rd;
    logic              wr;
  } xlate_res_t;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        wr_bank,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_lower,
  input  logic [31:0]                 wr_data,
  input  logic                        rd_bank,
  output logic [N_ENTRIES-1:0][31:0]  tag_o,
  output logic [N_ENTRIES-1:0][31:0]  tgt_o
);
  localparam int N_BANKS = 2;

  logic [31:0] tag_q [N_BANKS][N_ENTRIES];
  logic [31:0] tgt_q [N_BANKS][N_ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < N_BANKS; b++) begin
        for (int e = 0; e < N_ENTRIES; e++) begin
          tag_q[b][e] <= '0;
          tgt_q[b][e] <= '0;
        end
      end
    end else if (wr_en) begin
      if (wr_lower) tgt_q[wr_bank][wr_idx] <= wr_data;
      else          tag_q[wr_bank][wr_idx] <= wr_data;
    end
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_rd
    assign tag_o[e] = tag_q[rd_bank][e];
    assign tgt_o[e] = tgt_q[rd_bank][e];
  end
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
(
  input  logic [31:0]       tag_i,
  input  logic [31:0]       tgt_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic              user_i,
  output xlate_res_t        res_o
);
  logic [BLK_W-1:0] blk_mask;
  logic [BLK_W-1:0] va_blk;
  logic             seg_eq;
  logic             blk_eq;
  logic             priv_ok;

  assign blk_mask = tag_i[PAGE_LSB:2];
  assign va_blk   = va_i[SEG_LSB-1:BLK_LSB];
  assign seg_eq   = va_i[ADDR_W-1:SEG_LSB] == tag_i[ADDR_W-1:SEG_LSB];
  assign blk_eq   = (va_blk & ~blk_mask) == tag_i[SEG_LSB-1:BLK_LSB];
  assign priv_ok  = user_i ? tag_i[0] : tag_i[1];

  always_comb begin
    res_o.hit = seg_eq && blk_eq && priv_ok;
    res_o.pa  = {tgt_i[ADDR_W-1:SEG_LSB],
                 (va_blk & blk_mask) | tgt_i[SEG_LSB-1:BLK_LSB],
                 va_i[BLK_LSB-1:PAGE_LSB],
                 {PAGE_LSB{1'b0}}};
    res_o.wr  = tgt_i[1];
    res_o.rd  = tgt_i[1] | tgt_i[0];
  end
endmodule

// File: rtl/bat_pick.sv
module bat_pick
  import bat_pkg::*;
#(
  parameter int N_ENTRIES = 4
) (
  input  xlate_res_t [N_ENTRIES-1:0] cand_i,
  output xlate_res_t                 res_o,
  output logic [N_ENTRIES-1:0]       grant_o
);
  always_comb begin
    res_o   = '0;
    grant_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (cand_i[i].hit) begin
        res_o      = cand_i[i];
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_bank,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_lower,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic              req_fetch,
  input  logic              req_user,
  input  logic [31:0]       req_va,
  input  logic              xlate_instr_en,
  input  logic              xlate_data_en,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [31:0]       rsp_pa,
  output logic              rsp_rd,
  output logic              rsp_wr
);
  logic [N_ENTRIES-1:0][31:0] tag_w;
  logic [N_ENTRIES-1:0][31:0] tgt_w;
  xlate_res_t [N_ENTRIES-1:0] cand;
  xlate_res_t                 picked;
  xlate_res_t                 nxt;
  logic [N_ENTRIES-1:0]       grant;
  logic                       reloc_on;

  bat_regfile #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_bank (cfg_bank),
    .wr_idx  (cfg_idx),
    .wr_lower(cfg_lower),
    .wr_data (cfg_wdata),
    .rd_bank (req_fetch),
    .tag_o   (tag_w),
    .tgt_o   (tgt_w)
  );

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    bat_entry_match u_match (
      .tag_i (tag_w[e]),
      .tgt_i (tgt_w[e]),
      .va_i  (req_va),
      .user_i(req_user),
      .res_o (cand[e])
    );
  end

  bat_pick #(.N_ENTRIES(N_ENTRIES)) u_pick (
    .cand_i (cand),
    .res_o  (picked),
    .grant_o(grant)
  );

  assign reloc_on = req_fetch ? xlate_instr_en : xlate_data_en;

  always_comb begin
    if (!reloc_on) begin
      nxt.hit = 1'b1;
      nxt.pa  = {req_va[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      nxt.rd  = 1'b1;
      nxt.wr  = 1'b1;
    end else begin
      nxt = picked;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= nxt.hit;
      rsp_pa    <= nxt.pa;
      rsp_rd    <= nxt.rd;
      rsp_wr    <= nxt.wr;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !rsp_valid && !rsp_hit && !rsp_rd && !rsp_wr && rsp_pa == '0);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r11_miss_clean: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_hit |-> !rsp_rd && !rsp_wr && rsp_pa == '0);

  a_r7_write_implies_read: assert property (@(posedge clk) disable iff (rst)
    rsp_wr |-> rsp_rd);

  a_r6_offset_passes: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_pa[PAGE_LSB-1:0] == '0 &&
      (!rsp_hit || rsp_pa[BLK_LSB-1:PAGE_LSB] == $past(req_va[BLK_LSB-1:PAGE_LSB])));

  a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
    req_valid && !(req_fetch ? xlate_instr_en : xlate_data_en) |=>
      rsp_hit && rsp_rd && rsp_wr &&
      rsp_pa[ADDR_W-1:PAGE_LSB] == $past(req_va[ADDR_W-1:PAGE_LSB]));

  a_r8_single_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/bat_xlate_bench.sv
module bat_xlate_bench;
  localparam int N  = 4;
  localparam int IW = 2;

  typedef struct packed {
    logic        hit;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 0, cfg_bank = 0, cfg_lower = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          req_valid = 0, req_fetch = 0, req_user = 0;
  logic [31:0]   req_va = '0;
  logic          xlate_instr_en = 1, xlate_data_en = 1;
  logic          rsp_valid, rsp_hit, rsp_rd, rsp_wr;
  logic [31:0]   rsp_pa;

  bat_xlate #(.N_ENTRIES(N)) u_bat_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_idx(cfg_idx), .cfg_lower(cfg_lower), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_fetch(req_fetch), .req_user(req_user),
    .req_va(req_va), .xlate_instr_en(xlate_instr_en),
    .xlate_data_en(xlate_data_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr)
  );

  logic [31:0] sh_tag [2][N];
  logic [31:0] sh_tgt [2][N];
  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  function automatic exp_t model(bit fetch, bit user, logic [31:0] va, bit ien, bit den);
    exp_t r;
    bit   b;
    r = '0;
    b = fetch;
    if (!(fetch ? ien : den)) begin
      r.hit = 1; r.pa = {va[31:12], 12'h000}; r.rd = 1; r.wr = 1;
      return r;
    end
    for (int i = 0; i < N; i++) begin
      logic [31:0] t, g;
      logic [10:0] m;
      t = sh_tag[b][i];
      g = sh_tgt[b][i];
      m = t[12:2];
      if (va[31:28] == t[31:28] && (va[27:17] & ~m) == t[27:17] &&
          (user ? t[0] : t[1])) begin
        r.hit = 1;
        r.pa  = {g[31:28], (va[27:17] & m) | g[27:17], va[16:12], 12'h000};
        r.rd  = g[1] | g[0];
        r.wr  = g[1];
        return r;
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit do_wr, bit wbank, int widx, bit wlow, logic [31:0] wdata,
                      bit do_req, bit fetch, bit user, logic [31:0] va,
                      bit ien, bit den, string tag);
    @(negedge clk);
    cfg_we = do_wr; cfg_bank = wbank; cfg_idx = IW'(widx);
    cfg_lower = wlow; cfg_wdata = wdata;
    req_valid = do_req; req_fetch = fetch; req_user = user; req_va = va;
    xlate_instr_en = ien; xlate_data_en = den;
    if (do_req) begin
      exp_q.push_back(model(fetch, user, va, ien, den));
      tag_q.push_back(tag);
    end
    if (do_wr) begin
      if (wlow) sh_tgt[wbank][widx] = wdata;
      else      sh_tag[wbank][widx] = wdata;
    end
  endtask

  task automatic wr(bit bank, int idx, bit low, logic [31:0] d);
    step(1, bank, idx, low, d, 0, 0, 0, '0, 1, 1, "");
  endtask

  task automatic look(bit fetch, bit user, logic [31:0] va, bit ien, bit den, string tag);
    step(0, 0, 0, 0, '0, 1, fetch, user, va, ien, den, tag);
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_hit == e.hit, t, "hit", 64'(rsp_hit), 64'(e.hit));
        check(rsp_pa == e.pa, t, "pa", 64'(rsp_pa), 64'(e.pa));
        check({rsp_rd, rsp_wr} == {e.rd, e.wr}, t, "rd/wr",
              64'({rsp_rd, rsp_wr}), 64'({e.rd, e.wr}));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "R10", "watchdog", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < N; i++) begin sh_tag[b][i] = '0; sh_tgt[b][i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check({rsp_valid, rsp_hit, rsp_rd, rsp_wr} == 4'b0 && rsp_pa == '0, "R1",
          "reset outputs", 64'(rsp_pa), 64'd0);
    look(0, 0, 32'h0000_0000, 1, 1, "R1");
    look(0, 1, 32'h0000_0000, 1, 1, "R1");
    look(0, 0, 32'h1234_5678, 1, 0, "R9");
    look(1, 1, 32'hFEDC_BA98, 0, 1, "R9");
    look(1, 0, 32'h1234_5678, 1, 0, "R2");
    // data entry 2: segment 3, supervisor only, read/write
    wr(0, 2, 0, 32'h3000_0002);
    step(1, 0, 2, 1, 32'h8000_0002, 1, 0, 0, 32'h3001_2345, 1, 1, "R10");
    look(0, 0, 32'h3001_2345, 1, 1, "R6");
    look(0, 0, 32'h3001_F000, 1, 1, "R7");
    look(0, 1, 32'h3001_2345, 1, 1, "R5");
    look(1, 0, 32'h3001_2345, 1, 1, "R2");
    look(0, 0, 32'h3002_0000, 1, 1, "R4");
    // data entry 1: segment 4, 4-bit block mask, both privileges, read-only
    wr(0, 1, 0, 32'h4040_003F);
    wr(0, 1, 1, 32'h5060_0001);
    look(0, 1, 32'h405A_B000, 1, 1, "R4");
    look(0, 0, 32'h405A_B000, 1, 1, "R6");
    look(0, 1, 32'h4080_0000, 1, 1, "R4");
    look(0, 1, 32'h5040_0000, 1, 1, "R3");
    look(0, 1, 32'h4040_0000, 1, 1, "R7");
    // data entry 0 overlaps entry 1, supervisor only
    wr(0, 0, 0, 32'h4040_0002);
    wr(0, 0, 1, 32'h7000_0002);
    look(0, 0, 32'h4041_0000, 1, 1, "R8");
    look(0, 1, 32'h4041_0000, 1, 1, "R8");
    look(0, 0, 32'h405A_B000, 1, 1, "R8");
    // instruction entry 3: full mask, user only, no permission
    wr(1, 3, 0, 32'h0000_1FFD);
    wr(1, 3, 1, 32'h9000_0000);
    look(1, 1, 32'h0ABC_D000, 1, 1, "R7");
    look(1, 0, 32'h0ABC_D000, 1, 1, "R5");
    look(0, 1, 32'h0ABC_D000, 1, 1, "R2");
    look(1, 1, 32'h1ABC_D000, 1, 1, "R11");
    step(0, 0, 0, 0, '0, 0, 0, 0, '0, 1, 1, "");
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10", "idle rsp_valid", 64'(rsp_valid), 64'd0);
    x = 32'h1357_9BDF;
    for (int k = 0; k < 48; k++) begin
      logic [31:0] va;
      x  = x * 32'd1664525 + 32'd1013904223;
      va = x;
      case (x[30:29])
        2'd0: va[31:28] = 4'h0;
        2'd1: va[31:28] = 4'h3;
        2'd2: va[31:28] = 4'h4;
        default: va[31:28] = 4'h8;
      endcase
      if (x[9]) va[27:21] = 7'h02;
      look(x[5], x[6], va, x[7] | x[11], x[8] | x[12], "R6");
    end
    step(0, 0, 0, 0, '0, 0, 0, 0, '0, 1, 1, "");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", "pending responses", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule